// File: doc/BRIEF.md
# Effective Address Unit for an 8-bit Processor Core

This unit sits next to the instruction sequencer of an 8-bit processor with a 16-bit address space. When the sequencer pulses `start`, the unit takes an addressing-mode code, the two operand bytes that follow the opcode, the X and Y index registers and the program counter, which already points at the next instruction. It returns the 16-bit effective address together with a page-cross flag. The sequencer uses that flag to insert its extra read cycle.

Modes that need a pointer from memory fetch it one byte at a time over a small read port. The unit sends a one-cycle request with an address and waits for a data-valid strobe before it sends the next request. Both the original pointer fetch, whose second byte wraps inside its page, and the corrected variant with a full carry are available. The unit also supports zero-page indirect, absolute indexed indirect and a combined zero-page-plus-branch mode. A `done` pulse presents the result. The address and flag then hold until the next result.

Top module: `ea_unit`

## Requirements
- R1: Mode codes 0 (implied), 1 (implied X), 2 (implied Y), 3 (accumulator) and 4 (immediate) raise `done` on the first clock edge after `start`. They issue no read, and they give an address of 0 with the flag clear.
- R2: Modes 5 (zero page), 6 (zero page + X) and 7 (zero page + Y) finish one edge after `start` with no read. The address is the operand low byte, plus the index taken modulo 256, with a high byte of zero.
- R3: Mode 9 (absolute) returns {op_hi, op_lo}. Modes 10 and 11 (absolute + X) and mode 12 (absolute + Y) add the index unsigned to that base. The flag is set exactly when the result high byte differs from the base high byte. All of these finish one edge after `start`.
- R4: Mode 8 (relative) returns pc plus op_lo taken as a signed byte. The flag is set when the high byte changes.
- R5: Mode 19 (zero page + relative) returns pc plus op_hi taken as a signed byte. It never sets the flag.
- R6: Mode 14 (zero-page indexed indirect) reads the pointer low byte at zero-page address (op_lo + X) mod 256 and the high byte at that address + 1 mod 256. It returns the pointer and never sets the flag.
- R7: Mode 15 (zero-page indirect then + Y) and mode 17 (zero-page indirect) read the pointer at op_lo and (op_lo + 1) mod 256 in page zero. Mode 15 adds Y unsigned and flags a high-byte change. Mode 17 returns the pointer as it is.
- R8: Mode 13 (original indirect) reads the pointer at {op_hi, op_lo} and at {op_hi, op_lo + 1 mod 256}. Mode 16 (fixed indirect) reads the second byte at {op_hi, op_lo} + 1 with a full carry.
- R9: Mode 18 (absolute indexed indirect) reads the pointer at {op_hi, op_lo} + X, using full 16-bit arithmetic, and at that address + 1.
- R10: When `is_write` is high at `start`, the flag is reported clear for every mode except mode 11, which keeps it.
- R11: Codes 20 to 31 raise `bad_mode` with `done` one edge after `start`. They issue no read, and they give an address of 0 with the flag clear.
- R12: Each pointer byte is a one-cycle `rd_req`, and a second request waits for `rd_valid`. The low byte is read first. `done` rises on the edge that samples the second `rd_valid`. A `start` that arrives while a fetch is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a resolution; operands sampled on this edge |
| mode | input | 5 | Addressing-mode code |
| is_write | input | 1 | Access is a write (masks the flag) |
| op_lo | input | 8 | First operand byte |
| op_hi | input | 8 | Second operand byte |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| pc | input | 16 | Address of the next instruction |
| rd_req | output | 1 | One-cycle pointer read request |
| rd_addr | output | 16 | Pointer read address |
| rd_valid | input | 1 | Read data valid strobe |
| rd_data | input | 8 | Read data byte |
| done | output | 1 | Result valid pulse |
| ea | output | 16 | Effective address |
| page_cross | output | 1 | Page-cross penalty flag |
| bad_mode | output | 1 | Undefined mode code |

## Verification
Modes without a pointer must show `done` exactly one clock after `start`. The bench drives `start` on a falling edge and checks `done` on the very next falling edge, so one extra register stage is caught. Pointer modes have no fixed latency because the memory model answers 1 to 3 cycles after each request. For these modes the bench waits falling edge by falling edge for `done`, then compares the address, the flag, the number of requests and both request addresses against its own model. A stray `start` is injected during one fetch, and the two clocks after that `done` are checked to stay quiet.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [4:0] {
    M_IMPL    = 5'd0,
    M_IMPL_X  = 5'd1,
    M_IMPL_Y  = 5'd2,
    M_ACC     = 5'd3,
    M_IMM     = 5'd4,
    M_ZP      = 5'd5,
    M_ZPX     = 5'd6,
    M_ZPY     = 5'd7,
    M_REL     = 5'd8,
    M_ABS     = 5'd9,
    M_ABSX    = 5'd10,
    M_ABSX_W  = 5'd11,
    M_ABSY    = 5'd12,
    M_IND     = 5'd13,
    M_ZPX_IND = 5'd14,
    M_ZP_INDY = 5'd15,
    M_IND_FIX = 5'd16,
    M_ZP_IND  = 5'd17,
    M_ABSX_IND= 5'd18,
    M_ZP_REL  = 5'd19
  } ea_mode_e;

  localparam logic [4:0] MODE_MAX = 5'd19;

  typedef enum logic [1:0] {S_IDLE, S_WAIT_LO, S_WAIT_HI} ea_state_e;
endpackage

// File: rtl/ea_offset_add.sv
module ea_offset_add #(
  parameter int DW = 8
) (
  input  logic [2*DW-1:0] base,
  input  logic [DW-1:0]   off,
  input  logic            sgn,
  output logic [2*DW-1:0] sum,
  output logic            crossed
);
  localparam int AW = 2 * DW;

  logic [AW-1:0] ext;

  always_comb begin
    ext     = sgn ? {{DW{off[DW-1]}}, off} : {{DW{1'b0}}, off};
    sum     = base + ext;
    crossed = (sum[AW-1:DW] != base[AW-1:DW]);
  end
endmodule

// File: rtl/ea_ptr_addr.sv
module ea_ptr_addr
  import ea_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [4:0]      mode,
  input  logic [DW-1:0]   op_lo,
  input  logic [DW-1:0]   op_hi,
  input  logic [DW-1:0]   idx_x,
  output logic            need_ptr,
  output logic [2*DW-1:0] lo_addr,
  output logic [2*DW-1:0] hi_addr
);
  localparam int AW = 2 * DW;

  logic [DW-1:0] zp_ix, zp_ix_n, zp_n, lo_n;
  logic [AW-1:0] abs_a, abs_ix;

  always_comb begin
    zp_ix   = op_lo + idx_x;
    zp_ix_n = zp_ix + 1'b1;
    zp_n    = op_lo + 1'b1;
    lo_n    = op_lo + 1'b1;
    abs_a   = {op_hi, op_lo};
    abs_ix  = abs_a + {{DW{1'b0}}, idx_x};
    need_ptr = 1'b1;
    lo_addr  = '0;
    hi_addr  = '0;
    case (mode)
      M_ZPX_IND: begin
        lo_addr = {{DW{1'b0}}, zp_ix};
        hi_addr = {{DW{1'b0}}, zp_ix_n};
      end
      M_ZP_INDY, M_ZP_IND: begin
        lo_addr = {{DW{1'b0}}, op_lo};
        hi_addr = {{DW{1'b0}}, zp_n};
      end
      M_IND: begin
        lo_addr = abs_a;
        hi_addr = {op_hi, lo_n};
      end
      M_IND_FIX: begin
        lo_addr = abs_a;
        hi_addr = abs_a + 1'b1;
      end
      M_ABSX_IND: begin
        lo_addr = abs_ix;
        hi_addr = abs_ix + 1'b1;
      end
      default: need_ptr = 1'b0;
    endcase
  end
endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [4:0]    mode,
  input  logic          is_write,
  input  logic [DW-1:0] op_lo,
  input  logic [DW-1:0] op_hi,
  input  logic [DW-1:0] idx_x,
  input  logic [DW-1:0] idx_y,
  input  logic [AW-1:0] pc,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [DW-1:0] rd_data,
  output logic          done,
  output logic [AW-1:0] ea,
  output logic          page_cross,
  output logic          bad_mode
);
  ea_state_e     state;
  logic [4:0]    mode_q;
  logic          wr_q;
  logic [DW-1:0] y_q, lo_q;
  logic [AW-1:0] hi_addr_q;

  // pointer addresses from the raw inputs
  logic          need_ptr;
  logic [AW-1:0] p_lo, p_hi;

  ea_ptr_addr #(.DW(DW)) u_ptr (
    .mode(mode), .op_lo(op_lo), .op_hi(op_hi), .idx_x(idx_x),
    .need_ptr(need_ptr), .lo_addr(p_lo), .hi_addr(p_hi)
  );

  // direct path operand selection
  logic [AW-1:0] d_base, d_plain;
  logic [DW-1:0] d_off, zp_x, zp_y;
  logic          d_sgn, d_use_add, d_fe, d_bad;

  always_comb begin
    zp_x      = op_lo + idx_x;
    zp_y      = op_lo + idx_y;
    d_base    = {op_hi, op_lo};
    d_off     = '0;
    d_sgn     = 1'b0;
    d_use_add = 1'b0;
    d_fe      = 1'b0;
    d_plain   = '0;
    d_bad     = (mode > MODE_MAX);
    case (mode)
      M_ZP:  d_plain = {{DW{1'b0}}, op_lo};
      M_ZPX: d_plain = {{DW{1'b0}}, zp_x};
      M_ZPY: d_plain = {{DW{1'b0}}, zp_y};
      M_ABS: d_plain = {op_hi, op_lo};
      M_ABSX, M_ABSX_W: begin
        d_off = idx_x; d_use_add = 1'b1; d_fe = 1'b1;
      end
      M_ABSY: begin
        d_off = idx_y; d_use_add = 1'b1; d_fe = 1'b1;
      end
      M_REL: begin
        d_base = pc; d_off = op_lo; d_sgn = 1'b1; d_use_add = 1'b1; d_fe = 1'b1;
      end
      M_ZP_REL: begin
        d_base = pc; d_off = op_hi; d_sgn = 1'b1; d_use_add = 1'b1;
      end
      default: d_plain = '0;
    endcase
  end

  logic [AW-1:0] d_sum;
  logic          d_cross;

  ea_offset_add #(.DW(DW)) u_dadd (
    .base(d_base), .off(d_off), .sgn(d_sgn), .sum(d_sum), .crossed(d_cross)
  );

  // pointer path: final pointer plus optional Y
  logic [AW-1:0] p_sum;
  logic          p_cross;
  logic          p_add_y;

  assign p_add_y = (mode_q == M_ZP_INDY);

  ea_offset_add #(.DW(DW)) u_padd (
    .base({rd_data, lo_q}), .off(p_add_y ? y_q : '0), .sgn(1'b0),
    .sum(p_sum), .crossed(p_cross)
  );

  logic keep_now, keep_q;
  assign keep_now = !is_write || (mode == M_ABSX_W);
  assign keep_q   = !wr_q || (mode_q == M_ABSX_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      mode_q     <= '0;
      wr_q       <= 1'b0;
      y_q        <= '0;
      lo_q       <= '0;
      hi_addr_q  <= '0;
      rd_req     <= 1'b0;
      rd_addr    <= '0;
      done       <= 1'b0;
      ea         <= '0;
      page_cross <= 1'b0;
      bad_mode   <= 1'b0;
    end else begin
      done   <= 1'b0;
      rd_req <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          mode_q <= mode;
          wr_q   <= is_write;
          y_q    <= idx_y;
          if (need_ptr) begin
            rd_req    <= 1'b1;
            rd_addr   <= p_lo;
            hi_addr_q <= p_hi;
            state     <= S_WAIT_LO;
          end else begin
            done       <= 1'b1;
            bad_mode   <= d_bad;
            ea         <= d_bad ? '0 : (d_use_add ? d_sum : d_plain);
            page_cross <= !d_bad && d_use_add && d_fe && d_cross && keep_now;
          end
        end
        S_WAIT_LO: if (rd_valid) begin
          lo_q    <= rd_data;
          rd_req  <= 1'b1;
          rd_addr <= hi_addr_q;
          state   <= S_WAIT_HI;
        end
        S_WAIT_HI: if (rd_valid) begin
          done       <= 1'b1;
          bad_mode   <= 1'b0;
          ea         <= p_sum;
          page_cross <= p_add_y && p_cross && keep_q;
          state      <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R1 R2 R3 R11: modes without a pointer finish on the next edge
  a_r1_direct_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && start && !need_ptr) |=> done);

  // R2: zero-page modes stay in page zero
  a_r2_zp_page_zero: assert property (@(posedge clk) disable iff (rst)
    (done && (mode_q == M_ZP || mode_q == M_ZPX || mode_q == M_ZPY))
      |-> (ea[AW-1:DW] == '0));

  // R5: combined zero-page branch never flags
  a_r5_zprel_no_flag: assert property (@(posedge clk) disable iff (rst)
    (done && mode_q == M_ZP_REL) |-> !page_cross);

  // R6 R7: zero-page pointer reads never leave page zero
  a_r6_ptr_in_zp: assert property (@(posedge clk) disable iff (rst)
    (rd_req && (mode_q == M_ZPX_IND || mode_q == M_ZP_INDY || mode_q == M_ZP_IND))
      |-> (rd_addr[AW-1:DW] == '0));

  // R10: writes report no flag except the index-write mode
  a_r10_write_clears: assert property (@(posedge clk) disable iff (rst)
    (done && wr_q && mode_q != M_ABSX_W) |-> !page_cross);

  // R11: bad code gives a zero, unflagged result
  a_r11_bad_clean: assert property (@(posedge clk) disable iff (rst)
    (done && bad_mode) |-> (ea == '0 && !page_cross));

  // R12: requests are single-cycle pulses
  a_r12_req_pulse: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);

  // R12: no request and result in the same cycle
  a_r12_req_not_done: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> !done);
endmodule

// File: tb/ea_unit_tb.sv
module ea_unit_tb_top;
  import ea_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [4:0]  mode = '0;
  logic        is_write = 1'b0;
  logic [7:0]  op_lo = '0, op_hi = '0, idx_x = '0, idx_y = '0;
  logic [15:0] pc = '0;
  logic        rd_req;
  logic [15:0] rd_addr;
  logic        rd_valid = 1'b0;
  logic [7:0]  rd_data = '0;
  logic        done;
  logic [15:0] ea;
  logic        page_cross, bad_mode;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  ea_unit dut_i (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .is_write(is_write),
    .op_lo(op_lo), .op_hi(op_hi), .idx_x(idx_x), .idx_y(idx_y), .pc(pc),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .done(done), .ea(ea), .page_cross(page_cross), .bad_mode(bad_mode)
  );

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ 8'h5A;
  endfunction

  // memory responder and request monitor
  int          lat = 1;
  int          pend = 0;
  logic [15:0] pend_addr = '0;
  int          rd_total = 0;
  logic [15:0] rd_log [0:3];
  bit          overlap = 1'b0;

  always @(negedge clk) begin
    rd_valid <= 1'b0;
    if (rd_req) begin
      rd_log[rd_total % 4] <= rd_addr;
      rd_total <= rd_total + 1;
      if (pend != 0) overlap <= 1'b1;
    end
    if (pend != 0) begin
      pend <= pend - 1;
      if (pend == 1) begin
        rd_valid <= 1'b1;
        rd_data  <= mem_byte(pend_addr);
      end
    end else if (rd_req) begin
      pend_addr <= rd_addr;
      pend      <= lat;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: act %0d cycles exp below 150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act %h exp %h", req, act, exp);
    end
  endtask

  function automatic void ref_model(
    input logic [4:0] m, input logic [7:0] lo, hi, x, y, input logic [15:0] p,
    input bit wr, output logic [15:0] e, output bit c, output bit bad,
    output int nrd, output logic [15:0] a0, a1);
    logic [15:0] b, ptr;
    logic [7:0]  z;
    e = '0; c = 1'b0; bad = 1'b0; nrd = 0; a0 = '0; a1 = '0;
    b = {hi, lo};
    case (m)
      5'd0, 5'd1, 5'd2, 5'd3, 5'd4: e = '0;
      5'd5: e = {8'h00, lo};
      5'd6: begin z = lo + x; e = {8'h00, z}; end
      5'd7: begin z = lo + y; e = {8'h00, z}; end
      5'd9: e = b;
      5'd10, 5'd11: begin e = b + {8'h00, x}; c = (e[15:8] != b[15:8]); end
      5'd12: begin e = b + {8'h00, y}; c = (e[15:8] != b[15:8]); end
      5'd8: begin e = p + {{8{lo[7]}}, lo}; c = (e[15:8] != p[15:8]); end
      5'd19: e = p + {{8{hi[7]}}, hi};
      5'd13: begin z = lo + 8'd1; a0 = b; a1 = {hi, z}; nrd = 2; end
      5'd16: begin a0 = b; a1 = b + 16'd1; nrd = 2; end
      5'd14: begin z = lo + x; a0 = {8'h00, z}; z = z + 8'd1; a1 = {8'h00, z}; nrd = 2; end
      5'd15, 5'd17: begin z = lo + 8'd1; a0 = {8'h00, lo}; a1 = {8'h00, z}; nrd = 2; end
      5'd18: begin a0 = b + {8'h00, x}; a1 = a0 + 16'd1; nrd = 2; end
      default: bad = 1'b1;
    endcase
    if (nrd == 2) begin
      ptr = {mem_byte(a1), mem_byte(a0)};
      e = ptr;
      if (m == 5'd15) begin
        e = ptr + {8'h00, y};
        c = (e[15:8] != ptr[15:8]);
      end
    end
    if (wr && m != 5'd11) c = 1'b0;
  endfunction

  task automatic run_case(input logic [4:0] m, input logic [7:0] lo, hi, x, y,
                          input logic [15:0] p, input bit wr, input int l,
                          input bit inject, input string req);
    logic [15:0] e, a0, a1;
    bit c, bad;
    int nrd, base, k;
    bit got;
    ref_model(m, lo, hi, x, y, p, wr, e, c, bad, nrd, a0, a1);
    @(negedge clk);
    lat = l;
    base = rd_total;
    start = 1'b1; mode = m; op_lo = lo; op_hi = hi; idx_x = x; idx_y = y;
    pc = p; is_write = wr;
    @(negedge clk);
    start = 1'b0;
    got = done;
    k = 0;
    if (nrd == 0) begin
      chk(done == 1'b1, {req, " done one cycle after start"}, 32'(done), 32'd1);
    end else begin
      while (!done && k < 60) begin
        if (inject && k == 1) begin
          start = 1'b1; mode = 5'd5; op_lo = 8'h33;
        end else begin
          start = 1'b0;
        end
        @(negedge clk);
        k++;
      end
      start = 1'b0;
      got = done;
      chk(got, {req, " done seen"}, 32'(got), 32'd1);
    end
    if (got) begin
      chk(ea == e, {req, " address"}, 32'(ea), 32'(e));
      chk(page_cross == c, {req, " page flag"}, 32'(page_cross), 32'(c));
      chk(bad_mode == bad, {req, " bad code"}, 32'(bad_mode), 32'(bad));
    end
    chk((rd_total - base) == nrd, {req, " read count"}, 32'(rd_total - base), 32'(nrd));
    if (nrd == 2 && (rd_total - base) == 2) begin
      chk(rd_log[base % 4] == a0, {req, " first read addr"}, 32'(rd_log[base % 4]), 32'(a0));
      chk(rd_log[(base + 1) % 4] == a1, {req, " second read addr"},
          32'(rd_log[(base + 1) % 4]), 32'(a1));
    end
    if (inject) begin
      @(negedge clk);
      chk(done == 1'b0, "R12 stray start ignored (cycle 1)", 32'(done), 32'd0);
      @(negedge clk);
      chk(done == 1'b0 && rd_req == 1'b0, "R12 stray start ignored (cycle 2)",
          32'({done, rd_req}), 32'd0);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && rd_req == 1'b0 && ea == 16'h0000 && page_cross == 1'b0,
        "reset state", 32'({done, rd_req, page_cross}), 32'd0);
    rst = 1'b0;

    // R1 direct
    run_case(5'd0, 8'h12, 8'h34, 8'h01, 8'h02, 16'h1000, 0, 1, 0, "R1 implied");
    run_case(5'd4, 8'hAA, 8'h00, 8'h01, 8'h02, 16'h1000, 0, 1, 0, "R1 immediate");
    // R2 zero page wrap
    run_case(5'd6, 8'hF0, 8'h77, 8'h20, 8'h00, 16'h0000, 0, 1, 0, "R2 zp+X wrap");
    run_case(5'd7, 8'hFF, 8'h77, 8'h00, 8'h01, 16'h0000, 0, 1, 0, "R2 zp+Y wrap");
    // R3 absolute indexed
    run_case(5'd10, 8'hF0, 8'h10, 8'h20, 8'h00, 16'h0, 0, 1, 0, "R3 abs+X cross");
    run_case(5'd10, 8'h10, 8'h10, 8'h20, 8'h00, 16'h0, 0, 1, 0, "R3 abs+X no cross");
    run_case(5'd12, 8'hFF, 8'hFF, 8'h00, 8'h01, 16'h0, 0, 1, 0, "R3 abs+Y wrap top");
    // R4 relative
    run_case(5'd8, 8'hFE, 8'h00, 8'h0, 8'h0, 16'h1000, 0, 1, 0, "R4 backward cross");
    run_case(5'd8, 8'h7F, 8'h00, 8'h0, 8'h0, 16'h1010, 0, 1, 0, "R4 forward same page");
    // R5 zp+relative
    run_case(5'd19, 8'h44, 8'h80, 8'h0, 8'h0, 16'h2000, 0, 1, 0, "R5 zp+rel back no flag");
    // R6 zp,X indirect wrap
    run_case(5'd14, 8'hFF, 8'h00, 8'h01, 8'h0, 16'h0, 0, 2, 0, "R6 zp,X indirect wrap");
    run_case(5'd14, 8'hFE, 8'h00, 8'h01, 8'h0, 16'h0, 0, 1, 0, "R6 pointer at FF");
    // R7
    run_case(5'd15, 8'hFF, 8'h00, 8'h0, 8'hFF, 16'h0, 0, 3, 0, "R7 zp),Y wrap pointer");
    run_case(5'd17, 8'h80, 8'h00, 8'h0, 8'hFF, 16'h0, 0, 1, 0, "R7 zp indirect");
    // R8 indirect page bug and fix
    run_case(5'd13, 8'hFF, 8'h30, 8'h0, 8'h0, 16'h0, 0, 2, 0, "R8 original indirect at page end");
    run_case(5'd16, 8'hFF, 8'h30, 8'h0, 8'h0, 16'h0, 0, 2, 0, "R8 fixed indirect carry");
    // R9
    run_case(5'd18, 8'hFF, 8'h40, 8'h01, 8'h0, 16'h0, 0, 1, 0, "R9 abs+X indirect carry");
    // R10 writes
    run_case(5'd10, 8'hF0, 8'h10, 8'h20, 8'h0, 16'h0, 1, 1, 0, "R10 write abs+X cleared");
    run_case(5'd11, 8'hF0, 8'h10, 8'h20, 8'h0, 16'h0, 1, 1, 0, "R10 write index mode kept");
    run_case(5'd15, 8'h10, 8'h00, 8'h0, 8'hFF, 16'h0, 1, 1, 0, "R10 write zp),Y cleared");
    // R11 bad codes
    run_case(5'd20, 8'h11, 8'h22, 8'h0, 8'h0, 16'h0, 0, 1, 0, "R11 code 20");
    run_case(5'd31, 8'h11, 8'h22, 8'h0, 8'h0, 16'h0, 0, 1, 0, "R11 code 31");
    // R12 ignored start during fetch
    run_case(5'd16, 8'h20, 8'h50, 8'h0, 8'h0, 16'h0, 0, 3, 1, "R12 busy");

    // random mix
    for (int i = 0; i < 300; i++) begin
      run_case(5'($urandom % 22), 8'($urandom), 8'($urandom), 8'($urandom),
               8'($urandom), 16'($urandom), bit'($urandom % 2),
               1 + int'($urandom % 3), 0, "R3 random mode mix");
    end

    chk(overlap == 1'b0, "R12 one outstanding read", 32'(overlap), 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule